// File: doc/BRIEF.md
# USB Setup Request Dispatcher

This block sits behind a USB packet engine and receives the eight bytes of each control-transfer SETUP packet. Bytes arrive one per cycle on a valid strobe. A separate end-of-packet pulse then marks the whole packet as good or bad. Once a good packet of exactly eight bytes has ended, the block sorts the request into one of two groups.

Standard requests that the device completes on its own go to an internal auto-responder. They are sent as a one-cycle command strobe that carries the decoded fields. No interrupt is raised for them, and the data and status stages are run by that responder.

Every other request is stored whole in an eight-byte setup buffer, and a buffered-setup flag and interrupt are raised. Firmware then reads the request one byte per read through a single byte-wide port. It drops the flag by writing 1 to its clear input.

Top module: `usb_setup_dispatch`

## Requirements
- R1: A request with bits 6:5 of byte 0 equal to 00 and a byte 1 code of 0, 1, 3, 5, 8, 9, 10 or 11 is handled in hardware. `cmd_strobe` is high for exactly one cycle, in the cycle after the end-of-packet cycle. `setup_flag` and `irq` do not rise.
- R2: The request is forwarded to firmware if bits 6:5 of byte 0 are not 00, or if the type is standard and the code is 6, 7, 12 or any other unlisted value. `setup_flag` rises in the cycle after the end-of-packet cycle, and `cmd_strobe` stays low.
- R3: While `cmd_strobe` is high, the command fields are little-endian. `cmd_request` is byte 1. `cmd_value` is {byte 3, byte 2}, `cmd_index` is {byte 5, byte 4} and `cmd_length` is {byte 7, byte 6}.
- R4: A packet is discarded if it ends with `rx_good` low, or if it carries fewer or more than eight bytes. A discarded packet raises no strobe and sets no flag.
- R5: `irq` is high exactly when `setup_flag` is high.
- R6: When the flag is set, the read pointer goes back to byte 0. `rd_data` shows the byte at the pointer, and each cycle with `rd_en` high advances the pointer by one. After the eighth byte, `rd_data` reads 0.
- R7: A cycle with `flag_clr` high clears `setup_flag`. A new forwarded packet overwrites the buffer, sets the flag again and moves the pointer back to byte 0, whatever the flag's earlier state.
- R8: After reset, `setup_flag`, `irq` and `cmd_strobe` are low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A setup byte is present on rx_byte |
| rx_byte | input | 8 | Received setup byte |
| rx_eop | input | 1 | End-of-packet pulse, sent in a cycle with no byte |
| rx_good | input | 1 | The packet that is ending was received without error |
| cmd_strobe | output | 1 | One-cycle command to the auto-responder |
| cmd_request | output | 8 | Request code |
| cmd_value | output | 16 | Request value field |
| cmd_index | output | 16 | Request index field |
| cmd_length | output | 16 | Request length field |
| setup_flag | output | 1 | A forwarded setup is waiting in the buffer |
| irq | output | 1 | Interrupt request |
| rd_en | input | 1 | Firmware read: advance the buffer pointer |
| rd_data | output | 8 | Buffer byte at the read pointer |
| flag_clr | input | 1 | Write-one-to-clear for setup_flag |

## Verification
Packets go in with the standard type and codes from the hardware-handled set. They are compared against packets whose type is standard but whose codes must be forwarded, and against class and vendor requests that reuse a hardware-handled code. This shows that the split depends on both the type bits and the request code. Packets with different field values expose swapped or misordered bytes in the little-endian assembly. Bad-status, seven-byte and nine-byte packets show that only complete, good packets have any effect. A second forwarded packet arriving after a partial read shows that the buffer is overwritten and the pointer rewinds.

// File: rtl/usb_setup_pkg.sv
package usb_setup_pkg;
    localparam int SETUP_LEN = 8;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic [7:0]  request;
        logic [15:0] value;
        logic [15:0] index;
        logic [15:0] length;
    } setup_cmd_t;

    // Standard request codes that the device completes without firmware
    function automatic logic hw_handled(input byte_t rtype, input byte_t code);
        logic is_std;
        logic known;
        is_std = (rtype[6:5] == 2'b00);
        case (code)
            8'd0, 8'd1, 8'd3, 8'd5, 8'd8, 8'd9, 8'd10, 8'd11: known = 1'b1;
            default: known = 1'b0;
        endcase
        return is_std && known;
    endfunction
endpackage

// File: rtl/setup_capture.sv
module setup_capture
    import usb_setup_pkg::*;
#(
    parameter int LEN = SETUP_LEN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    input  logic                  rx_eop,
    input  logic                  rx_good,
    output logic [LEN-1:0][7:0]   pkt_bytes,
    output logic                  pkt_ok
);
    localparam int CNT_W = $clog2(LEN + 2);
    localparam int IDX_W = $clog2(LEN);

    typedef struct packed {
        logic [LEN-1:0][7:0] data;
        logic [CNT_W-1:0]    cnt;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_valid) begin
            if (st_q.cnt < CNT_W'(LEN))
                st_d.data[st_q.cnt[IDX_W-1:0]] = rx_byte;
            if (st_q.cnt <= CNT_W'(LEN))
                st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rx_eop)
            st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_bytes = st_q.data;
    assign pkt_ok    = rx_eop && rx_good && (st_q.cnt == CNT_W'(LEN));

    // R4: a packet count never runs past one beyond the setup length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(LEN + 1));
endmodule

// File: rtl/setup_classify.sv
module setup_classify
    import usb_setup_pkg::*;
#(
    parameter int LEN = SETUP_LEN
) (
    input  logic [LEN-1:0][7:0] pkt_bytes,
    output logic                is_hw,
    output setup_cmd_t          cmd
);
    always_comb begin
        is_hw       = hw_handled(pkt_bytes[0], pkt_bytes[1]);
        cmd.request = pkt_bytes[1];
        cmd.value   = {pkt_bytes[3], pkt_bytes[2]};
        cmd.index   = {pkt_bytes[5], pkt_bytes[4]};
        cmd.length  = {pkt_bytes[7], pkt_bytes[6]};
    end
endmodule

// File: rtl/setup_fifo.sv
module setup_fifo
    import usb_setup_pkg::*;
#(
    parameter int LEN = SETUP_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [LEN-1:0][7:0] load_bytes,
    input  logic                rd_en,
    input  logic                flag_clr,
    output logic [7:0]          rd_data,
    output logic                flag
);
    localparam int PTR_W = $clog2(LEN + 1);
    localparam int IDX_W = $clog2(LEN);

    typedef struct packed {
        logic [LEN-1:0][7:0] mem;
        logic [PTR_W-1:0]    ptr;
        logic                flag;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en && st_q.ptr < PTR_W'(LEN))
            st_d.ptr = st_q.ptr + 1'b1;
        if (flag_clr)
            st_d.flag = 1'b0;
        if (load) begin
            st_d.mem  = load_bytes;
            st_d.ptr  = '0;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = (st_q.ptr < PTR_W'(LEN)) ? st_q.mem[st_q.ptr[IDX_W-1:0]] : 8'h00;
    assign flag    = st_q.flag;

    // R6: the read pointer stops one past the last byte
    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= PTR_W'(LEN));
    // R7: a clear without a new load drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !load) |=> !flag);
endmodule

// File: rtl/usb_setup_dispatch.sv
module usb_setup_dispatch
    import usb_setup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eop,
    input  logic        rx_good,
    output logic        cmd_strobe,
    output logic [7:0]  cmd_request,
    output logic [15:0] cmd_value,
    output logic [15:0] cmd_index,
    output logic [15:0] cmd_length,
    output logic        setup_flag,
    output logic        irq,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        flag_clr
);
    logic [SETUP_LEN-1:0][7:0] pkt_bytes;
    logic                      pkt_ok;
    logic                      is_hw;
    setup_cmd_t                cmd_dec;

    setup_capture #(.LEN(SETUP_LEN)) u_capture (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_eop(rx_eop), .rx_good(rx_good), .pkt_bytes(pkt_bytes), .pkt_ok(pkt_ok)
    );

    setup_classify #(.LEN(SETUP_LEN)) u_classify (
        .pkt_bytes(pkt_bytes), .is_hw(is_hw), .cmd(cmd_dec)
    );

    setup_fifo #(.LEN(SETUP_LEN)) u_fifo (
        .clk(clk), .rst_n(rst_n), .load(pkt_ok && !is_hw), .load_bytes(pkt_bytes),
        .rd_en(rd_en), .flag_clr(flag_clr), .rd_data(rd_data), .flag(setup_flag)
    );

    typedef struct packed {
        logic       strobe;
        setup_cmd_t cmd;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d        = out_q;
        out_d.strobe = pkt_ok && is_hw;
        if (pkt_ok && is_hw)
            out_d.cmd = cmd_dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cmd_strobe  = out_q.strobe;
    assign cmd_request = out_q.cmd.request;
    assign cmd_value   = out_q.cmd.value;
    assign cmd_index   = out_q.cmd.index;
    assign cmd_length  = out_q.cmd.length;
    assign irq         = setup_flag;

    // R1: a hardware command never comes together with a new buffered setup
    p_hw_no_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> !$rose(setup_flag));
    // R1: the command strobe lasts a single cycle
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);
    // R2: the flag only rises after a good end of packet
    p_flag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_flag) |-> $past(rx_eop && rx_good));
    // R4: a bad end of packet causes neither a strobe nor a flag
    p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eop && !rx_good) |=> (!cmd_strobe && !$rose(setup_flag)));
endmodule

// File: tb/sim_usb_setup_dispatch.sv
module sim_usb_setup_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_eop = 1'b0, rx_good = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rd_en = 1'b0, flag_clr = 1'b0;
    logic        cmd_strobe, setup_flag, irq;
    logic [7:0]  cmd_request, rd_data;
    logic [15:0] cmd_value, cmd_index, cmd_length;

    int checks = 0;
    int failures = 0;
    logic [55:0] exp_q[$];

    always #4 clk = ~clk;

    usb_setup_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_eop(rx_eop), .rx_good(rx_good), .cmd_strobe(cmd_strobe),
        .cmd_request(cmd_request), .cmd_value(cmd_value), .cmd_index(cmd_index),
        .cmd_length(cmd_length), .setup_flag(setup_flag), .irq(irq),
        .rd_en(rd_en), .rd_data(rd_data), .flag_clr(flag_clr)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_hw(input logic [7:0] t, input logic [7:0] c);
        return (t[6:5] == 2'b00) && (c inside {8'd0, 8'd1, 8'd3, 8'd5, 8'd8, 8'd9, 8'd10, 8'd11});
    endfunction

    // Monitor: pops expected commands whenever the design strobes
    always @(negedge clk) begin
        if (rst_n && cmd_strobe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected strobe", 64'(cmd_request), 64'hff);
            end else begin
                logic [55:0] e;
                e = exp_q.pop_front();
                check({cmd_request, cmd_value, cmd_index, cmd_length} == e, "R3 command fields",
                      64'({cmd_request, cmd_value, cmd_index, cmd_length}), 64'(e));
            end
            check(!setup_flag, "R1 no flag with strobe", 64'(setup_flag), 64'h0);
        end
    end

    // Driver: sends n bytes from b, then the end-of-packet pulse
    task automatic send(input logic [7:0] b[12], input int n, input logic good);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = b[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eop   = 1'b1;
        rx_good  = good;
        if (good && n == 8 && model_hw(b[0], b[1]))
            exp_q.push_back({b[1], b[3], b[2], b[5], b[4], b[7], b[6]});
        @(negedge clk);
        rx_eop  = 1'b0;
        rx_good = 1'b0;
    endtask

    task automatic read_check(input logic [7:0] exp, input string tag);
        check(rd_data == exp, tag, 64'(rd_data), 64'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(!setup_flag && !irq, "R7 flag cleared", 64'({setup_flag, irq}), 64'h0);
    endtask

    initial begin
        #2000000;
        check(1'b0, "watchdog expired", 64'h0, 64'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] p[12];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!setup_flag && !irq && !cmd_strobe && rd_data == 8'h00, "R8 reset state",
              64'({setup_flag, irq, cmd_strobe, rd_data}), 64'h0);

        // R1 R3: SET_ADDRESS, GET_STATUS with direction bit, SET_INTERFACE
        p = '{8'h00, 8'h05, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        p = '{8'h80, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h02, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        p = '{8'h01, 8'h0B, 8'h02, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        p = '{8'h00, 8'h09, 8'hA5, 8'h5A, 8'h34, 8'h12, 8'h78, 8'h56, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        check(!setup_flag, "R1 hardware set leaves flag low", 64'(setup_flag), 64'h0);

        // R2 R5 R6: GET_DESCRIPTOR goes to firmware
        p = '{8'h80, 8'h06, 8'h00, 8'h01, 8'h00, 8'h00, 8'h40, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        check(setup_flag && irq, "R2 R5 forwarded sets flag and irq", 64'({setup_flag, irq}), 64'h3);
        for (int i = 0; i < 8; i++) read_check(p[i], "R6 read byte");
        read_check(8'h00, "R6 read past end");
        read_check(8'h00, "R6 read past end again");
        clear_flag();

        // R2 R7: class request reusing code 9, partial read, then vendor overwrite
        p = '{8'h21, 8'h09, 8'h00, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        check(setup_flag, "R2 class request forwarded", 64'(setup_flag), 64'h1);
        read_check(8'h21, "R6 class byte 0");
        read_check(8'h09, "R6 class byte 1");
        p = '{8'hC0, 8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        check(setup_flag, "R7 flag set again", 64'(setup_flag), 64'h1);
        read_check(8'hC0, "R7 overwrite rewinds to byte 0");
        read_check(8'h01, "R7 overwrite byte 1");
        clear_flag();

        // R4: bad status, short and long packets of a hardware request
        p = '{8'h00, 8'h09, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0};
        send(p, 8, 1'b0);
        check(!setup_flag && exp_q.size() == 0, "R4 bad packet ignored", 64'(setup_flag), 64'h0);
        send(p, 7, 1'b1);
        check(!setup_flag, "R4 short packet ignored", 64'(setup_flag), 64'h0);
        send(p, 9, 1'b1);
        check(!setup_flag, "R4 long packet ignored", 64'(setup_flag), 64'h0);
        p = '{8'h80, 8'h06, 8'h00, 8'h01, 8'h00, 8'h00, 8'h40, 8'h00, 0, 0, 0, 0};
        send(p, 7, 1'b1);
        check(!setup_flag, "R4 short forwarded packet ignored", 64'(setup_flag), 64'h0);
        send(p, 8, 1'b0);
        check(!setup_flag, "R4 bad forwarded packet ignored", 64'(setup_flag), 64'h0);

        // R2: SYNCH_FRAME and an unknown standard code
        p = '{8'h82, 8'h0C, 8'h00, 8'h00, 8'h81, 8'h00, 8'h02, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        check(setup_flag, "R2 sync frame forwarded", 64'(setup_flag), 64'h1);
        read_check(8'h82, "R6 sync byte 0");
        clear_flag();
        p = '{8'h00, 8'h0D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0};
        send(p, 8, 1'b1);
        check(setup_flag, "R2 unknown code forwarded", 64'(setup_flag), 64'h1);
        p = '{8'h00, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0};
        clear_flag();
        send(p, 8, 1'b1);
        check(setup_flag, "R2 set descriptor forwarded", 64'(setup_flag), 64'h1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all hardware commands seen", 64'(exp_q.size()), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule